// File: doc/BRIEF.md
# DRAM Power-Up and Parallel Test Sequencer

This block sits on the controller side of an asynchronous fast-page or EDO DRAM and drives its row strobe, column strobe, write enable and multiplexed address pins. After reset it keeps every strobe inactive for a power-up interval. It then runs a fixed number of CAS-before-RAS refresh cycles to initialize the array. Only after those cycles does it report that it is ready to accept commands.

Once ready, it takes four commands. One enters the part's latched parallel test mode with a CAS-before-RAS cycle that holds write enable low. One performs a test-mode read and reports the one-bit agreement result sampled from DQ. The other two leave test mode, either with a CAS-before-RAS refresh or with a RAS-only refresh. Each timing interval is set by a parameter that counts clock cycles. The extra access time that test mode adds is given in nanoseconds and rounded up to whole clocks. A command that arrives while a cycle is running is dropped.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, ras_n, cas_n and we_n stay high, ready is 0 and busy is 1 for at least PWRUP_US microseconds (PWRUP_US*1000/CLK_PERIOD_NS clock cycles) before any strobe falls.
- R2: After the power-up wait, exactly INIT_CYCLES refresh cycles are issued before ready rises. In each one, cas_n falls before ras_n while we_n is high.
- R3: Command code 2'b00 (enter) issues a cycle in which cas_n falls before ras_n and we_n is low when ras_n falls. test_active rises together with that ras_n fall.
- R4: test_active stays 1 through test reads and ignored commands until an exit cycle is issued.
- R5: Command code 2'b01 (test read) drives the row on addr with ras_n low, then the column with cas_n low. result_valid then pulses for one cycle, and result_pass gives the sampled DQ level (1 = high = pass, 0 = low = fail).
- R6: DQ is sampled on the clock edge that ends T_CAC + ceil(TEST_XTRA_NS/CLK_PERIOD_NS) cycles of cas_n low during a test read.
- R7: In the column phase of a test read, addr bit 9 is driven 0 and the other column bits pass through unchanged.
- R8: Command code 2'b10 leaves test mode with a CAS-before-RAS cycle with we_n high. test_active falls together with that ras_n fall.
- R9: Command code 2'b11 leaves test mode with a RAS-only cycle in which cas_n stays high and addr carries cmd_row at the ras_n fall. test_active falls together with that ras_n fall.
- R10: A command presented while ready is 0 is ignored: it issues no cycle and does not change test_active.
- R11: A test read command issued while test_active is 0 is ignored. No strobe moves, no result_valid pulse is produced, and ready stays 1.
- R12: Between two ras_n low periods, ras_n stays high for at least T_RP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled while ready is 1 |
| cmd_op | input | 2 | Command code: 00 enter, 01 test read, 10 exit by CBR, 11 exit by RAS-only |
| cmd_row | input | ROW_W | Row address for test read and RAS-only exit |
| cmd_col | input | COL_W | Column address for test read |
| dq_in | input | 1 | Test-mode agreement bit from the DRAM |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Multiplexed DRAM address |
| ready | output | 1 | Idle and able to take a command |
| busy | output | 1 | Power-up, initialization or a cycle is in progress |
| test_active | output | 1 | The DRAM is latched in parallel test mode |
| result_valid | output | 1 | One-cycle pulse when a test read result is captured |
| result_pass | output | 1 | Result of the most recent test read |

## Verification
The assertions assume that cmd_valid and cmd_op only change away from the clock edge. They also assume dq_in holds a settled level at the edge that ends the column phase. The bench meets both by driving every input at the falling clock edge. The bench also models the DRAM's DQ: it gives the inverse of the intended result until CAS has been low for the full extended access time, so a sample taken one edge early reads the wrong level. Commands during busy periods are issued one cycle after an accepted command, while the cycle in progress is certain to be running.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
    typedef enum logic [2:0] {
        ST_PWRUP, ST_IDLE, ST_CBR_CSR, ST_CBR_RAS,
        ST_ROR_RAS, ST_RD_ROW, ST_RD_COL, ST_PRE
    } seq_st_e;

    typedef enum logic [1:0] {K_INIT, K_ENTER, K_EXIT, K_READ} seq_kind_e;

    localparam logic [1:0] OP_ENTER    = 2'd0;
    localparam logic [1:0] OP_READ     = 2'd1;
    localparam logic [1:0] OP_EXIT_CBR = 2'd2;
    localparam logic [1:0] OP_EXIT_ROR = 2'd3;
endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_W'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R1
    load_when_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> zero);
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int ROW_W       = 11,
    parameter int COL_W       = 10,
    parameter int CNT_W       = 16,
    parameter int INIT_CYCLES = 8,
    parameter int T_CSR       = 1,
    parameter int T_RAS       = 6,
    parameter int T_RP        = 4,
    parameter int T_RCD       = 3,
    parameter int T_COL       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [ROW_W-1:0] cmd_row,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             dq_in,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_st_e          st,
    output seq_kind_e        kind,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col,
    output logic             test_active,
    output logic             result_valid,
    output logic             result_pass
);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        seq_st_e          st;
        seq_kind_e        kind;
        logic [INIT_W-1:0] init_cnt;
        logic             test;
        logic             pass;
        logic             rv;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d        = q;
        d.rv     = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (tmr_zero) begin
            case (q.st)
                ST_PWRUP: begin
                    d.st = ST_CBR_CSR; d.kind = K_INIT;
                    tmr_load = 1'b1; tmr_val = CNT_W'(T_CSR - 1);
                end
                ST_IDLE: if (cmd_valid) begin
                    case (cmd_op)
                        OP_ENTER: begin
                            d.st = ST_CBR_CSR; d.kind = K_ENTER;
                            tmr_load = 1'b1; tmr_val = CNT_W'(T_CSR - 1);
                        end
                        OP_READ: if (q.test) begin
                            d.st = ST_RD_ROW; d.kind = K_READ;
                            d.row = cmd_row; d.col = cmd_col;
                            tmr_load = 1'b1; tmr_val = CNT_W'(T_RCD - 1);
                        end
                        OP_EXIT_CBR: begin
                            d.st = ST_CBR_CSR; d.kind = K_EXIT;
                            tmr_load = 1'b1; tmr_val = CNT_W'(T_CSR - 1);
                        end
                        default: begin
                            d.st = ST_ROR_RAS; d.kind = K_EXIT;
                            d.row = cmd_row; d.test = 1'b0;
                            tmr_load = 1'b1; tmr_val = CNT_W'(T_RAS - 1);
                        end
                    endcase
                end
                ST_CBR_CSR: begin
                    d.st = ST_CBR_RAS;
                    if (q.kind == K_ENTER) d.test = 1'b1;
                    if (q.kind == K_EXIT)  d.test = 1'b0;
                    tmr_load = 1'b1; tmr_val = CNT_W'(T_RAS - 1);
                end
                ST_CBR_RAS, ST_ROR_RAS: begin
                    d.st = ST_PRE;
                    tmr_load = 1'b1; tmr_val = CNT_W'(T_RP - 1);
                end
                ST_RD_ROW: begin
                    d.st = ST_RD_COL;
                    tmr_load = 1'b1; tmr_val = CNT_W'(T_COL - 1);
                end
                ST_RD_COL: begin
                    d.st = ST_PRE; d.pass = dq_in; d.rv = 1'b1;
                    tmr_load = 1'b1; tmr_val = CNT_W'(T_RP - 1);
                end
                default: begin
                    if (q.kind == K_INIT && q.init_cnt != INIT_W'(INIT_CYCLES - 1)) begin
                        d.init_cnt = q.init_cnt + 1'b1;
                        d.st = ST_CBR_CSR;
                        tmr_load = 1'b1; tmr_val = CNT_W'(T_CSR - 1);
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_PWRUP;
            q.kind     <= K_INIT;
            q.init_cnt <= '0;
            q.test     <= 1'b0;
            q.pass     <= 1'b0;
            q.rv       <= 1'b0;
            q.row      <= '0;
            q.col      <= '0;
        end else begin
            q <= d;
        end
    end

    assign st           = q.st;
    assign kind         = q.kind;
    assign row          = q.row;
    assign col          = q.col;
    assign test_active  = q.test;
    assign result_valid = q.rv;
    assign result_pass  = q.pass;

    // R2
    init_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.init_cnt < INIT_W'(INIT_CYCLES));
endmodule

// File: rtl/dram_seq_pins.sv
module dram_seq_pins
    import dram_seq_pkg::*;
#(
    parameter int ROW_W      = 11,
    parameter int COL_W      = 10,
    parameter int ADDR_W     = 11,
    parameter int COL_DC_BIT = 9
) (
    input  seq_st_e           st,
    input  seq_kind_e         kind,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);
    logic [COL_W-1:0] col_m;

    generate
        if (COL_DC_BIT < COL_W) begin : g_mask
            always_comb begin
                col_m = col;
                col_m[COL_DC_BIT] = 1'b0;
            end
        end else begin : g_nomask
            assign col_m = col;
        end
    endgenerate

    always_comb begin
        ras_n = !(st inside {ST_CBR_RAS, ST_ROR_RAS, ST_RD_ROW, ST_RD_COL});
        cas_n = !(st inside {ST_CBR_CSR, ST_CBR_RAS, ST_RD_COL});
        we_n  = !((st inside {ST_CBR_CSR, ST_CBR_RAS}) && kind == K_ENTER);
        case (st)
            ST_ROR_RAS, ST_RD_ROW: addr = ADDR_W'(row);
            ST_RD_COL:             addr = ADDR_W'(col_m);
            default:               addr = '0;
        endcase
    end
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dram_seq_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int PWRUP_US      = 200,
    parameter int INIT_CYCLES   = 8,
    parameter int T_CSR         = 1,
    parameter int T_RAS         = 6,
    parameter int T_RP          = 4,
    parameter int T_RCD         = 3,
    parameter int T_CAC         = 2,
    parameter int TEST_XTRA_NS  = 5,
    parameter int ROW_W         = 11,
    parameter int COL_W         = 10,
    parameter int COL_DC_BIT    = 9,
    localparam int ADDR_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              dq_in,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              busy,
    output logic              test_active,
    output logic              result_valid,
    output logic              result_pass
);
    localparam int T_XTRA    = (TEST_XTRA_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int T_COL     = T_CAC + T_XTRA;
    localparam int PWRUP_CYC = (PWRUP_US * 1000) / CLK_PERIOD_NS;
    localparam int MAX_LOAD  = (PWRUP_CYC > T_RAS + T_COL + T_RP + T_RCD) ?
                               PWRUP_CYC : (T_RAS + T_COL + T_RP + T_RCD);
    localparam int CNT_W     = $clog2(MAX_LOAD + 1);
    localparam int HI_W      = $clog2(T_RP + 1);

    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    seq_st_e          st;
    seq_kind_e        kind;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;

    dram_seq_timer #(.CNT_W(CNT_W), .RST_VAL(PWRUP_CYC - 1)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    dram_seq_fsm #(
        .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W), .INIT_CYCLES(INIT_CYCLES),
        .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD), .T_COL(T_COL)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .dq_in(dq_in), .tmr_zero(tmr_zero),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .st(st), .kind(kind), .row(row),
        .col(col), .test_active(test_active), .result_valid(result_valid),
        .result_pass(result_pass)
    );

    dram_seq_pins #(
        .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .COL_DC_BIT(COL_DC_BIT)
    ) pins_i (
        .st(st), .kind(kind), .row(row), .col(col),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
    );

    assign ready = (st == ST_IDLE);
    assign busy  = !ready;

    logic [HI_W-1:0] hi_cnt_d, hi_cnt_q;

    always_comb begin
        hi_cnt_d = '0;
        if (ras_n) hi_cnt_d = (hi_cnt_q == HI_W'(T_RP)) ? hi_cnt_q : hi_cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_cnt_q <= '0;
        else        hi_cnt_q <= hi_cnt_d;
    end

    // R12
    precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> hi_cnt_q >= HI_W'(T_RP));

    // R2
    strobe_skew_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(cas_n));

    // R3
    test_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_active) |-> (!ras_n && !cas_n && !we_n));

    // R8
    test_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_active) |-> ($fell(ras_n) && we_n));

    // R5
    result_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(!cas_n));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R11
    read_off_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cmd_valid && cmd_op == OP_READ && !test_active) |=> ready);
endmodule

// File: tb/dram_init_seq_tb_top.sv
module dram_init_seq_tb_top;
    localparam int PWRUP = 25000;
    localparam int INITC = 8;
    localparam int TRP   = 4;
    localparam int NCOL  = 2 + (5 + 8 - 1) / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [10:0] cmd_row = '0;
    logic [9:0] cmd_col = '0;
    logic dq_in = 1'b0;
    logic ras_n, cas_n, we_n, ready, busy, test_active, result_valid, result_pass;
    logic [10:0] addr;

    always #4 clk = ~clk;

    dram_init_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .dq_in(dq_in), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .ready(ready), .busy(busy),
        .test_active(test_active), .result_valid(result_valid), .result_pass(result_pass)
    );

    int checks = 0, errors = 0;
    int cyc = 0, n_fall = 0, first_cas = -1, hi_run = 0, min_hi = 1000;
    int rv_cnt = 0, col_lo = 0;
    bit fall_cbr, fall_we, fall_ror, all_init_cbr = 1'b1, ready_seen = 1'b0;
    bit prev_ras = 1'b1, prev_cas = 1'b1, dq_want = 1'b1;
    logic [10:0] fall_addr = '0, col_addr = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        cyc++;
        if (!cas_n && prev_cas && first_cas < 0) first_cas = cyc;
        if (!ras_n && prev_ras) begin
            n_fall++;
            fall_cbr  = !cas_n && !prev_cas;
            fall_we   = we_n;
            fall_ror  = cas_n;
            fall_addr = addr;
            if (n_fall > 1 && hi_run < min_hi) min_hi = hi_run;
            if (!ready_seen && !(fall_cbr && we_n)) all_init_cbr = 1'b0;
        end
        hi_run = ras_n ? hi_run + 1 : 0;
        if (ready) ready_seen = 1'b1;
        if (result_valid) rv_cnt++;
        if (!ras_n && !cas_n && we_n) begin
            col_lo++;
            col_addr = addr;
        end else begin
            col_lo = 0;
        end
        dq_in = (col_lo >= NCOL) ? dq_want : !dq_want;
        prev_ras = ras_n;
        prev_cas = cas_n;
    end

    task automatic send(input logic [1:0] op, input logic [10:0] r, input logic [9:0] c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_row = r; cmd_col = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_ready();
        int g = 0;
        while (!ready && g < 100000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic t_reset_state();
        #20;
        chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
        chk(!ready && busy, "R1 ready/busy in reset", {ready, busy}, 1);
    endtask

    task automatic t_init();
        wait_ready();
        chk(first_cas >= PWRUP, "R1 power-up delay", first_cas, PWRUP);
        chk(n_fall == INITC, "R2 init cycle count", n_fall, INITC);
        chk(all_init_cbr, "R2 init cycles are CBR with WE high", all_init_cbr, 1);
        chk(!test_active, "R2 test off after init", test_active, 0);
    endtask

    task automatic t_read_off();
        int n0 = n_fall, r0 = rv_cnt;
        send(2'b01, 11'h055, 10'h011);
        repeat (10) @(negedge clk);
        chk(n_fall == n0, "R11 no cycle when test off", n_fall - n0, 0);
        chk(rv_cnt == r0 && ready, "R11 no result, still ready", rv_cnt - r0, 0);
    endtask

    task automatic t_enter();
        int n0 = n_fall;
        send(2'b00, '0, '0);
        wait_ready();
        chk(n_fall == n0 + 1, "R3 one entry cycle", n_fall - n0, 1);
        chk(fall_cbr && !fall_we, "R3 WCBR strobe order", {fall_cbr, fall_we}, 2);
        chk(test_active, "R3 test_active set", test_active, 1);
    endtask

    task automatic t_read(input bit want, input logic [9:0] c, input string tag);
        int r0 = rv_cnt;
        dq_want = want;
        send(2'b01, 11'h2C3, c);
        wait_ready();
        chk(rv_cnt == r0 + 1, {"R5 one result pulse ", tag}, rv_cnt - r0, 1);
        chk(result_pass == want, {"R6 DQ sampled after extended CAS ", tag}, result_pass, want);
        chk(fall_addr == 11'h2C3, {"R5 row address ", tag}, fall_addr, 11'h2C3);
        chk(col_addr == {1'b0, c & 10'h1FF}, {"R7 column bit 9 masked ", tag},
            col_addr, {1'b0, c & 10'h1FF});
        chk(test_active, {"R4 test mode held ", tag}, test_active, 1);
    endtask

    task automatic t_busy_reject();
        int n0 = n_fall;
        dq_want = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_row = 11'h010; cmd_col = 10'h020;
        @(negedge clk);
        cmd_op = 2'b11;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_ready();
        chk(n_fall == n0 + 1, "R10 command during busy ignored", n_fall - n0, 1);
        chk(test_active, "R10 test mode unchanged", test_active, 0 + 1);
    endtask

    task automatic t_exit_cbr();
        int n0 = n_fall;
        send(2'b10, '0, '0);
        wait_ready();
        chk(n_fall == n0 + 1 && fall_cbr && fall_we, "R8 CBR exit cycle",
            {fall_cbr, fall_we}, 3);
        chk(!test_active, "R8 test_active cleared", test_active, 0);
    endtask

    task automatic t_exit_ror();
        int n0;
        send(2'b00, '0, '0);
        wait_ready();
        n0 = n_fall;
        send(2'b11, 11'h5A5, '0);
        wait_ready();
        chk(n_fall == n0 + 1 && fall_ror, "R9 RAS-only exit with CAS high", fall_ror, 1);
        chk(fall_addr == 11'h5A5, "R9 row on addr", fall_addr, 11'h5A5);
        chk(!test_active, "R9 test_active cleared", test_active, 0);
        chk(min_hi >= TRP, "R12 precharge width", min_hi, TRP);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        t_init();
        t_read_off();
        t_enter();
        t_read(1'b1, 10'h3A5, "pass");
        t_read(1'b0, 10'h1C7, "fail");
        t_busy_reject();
        t_exit_cbr();
        t_exit_ror();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule